// File: doc/BRIEF.md
# ALU Operation Select Decoder

This block is the second level of a two-level instruction control scheme. The main controller reduces each opcode to a 3-bit operation class. This decoder turns that class into the 3-bit select that steers the ALU. Immediate, load/store and branch classes name their ALU operation directly: OR, ADD or SUBTRACT. The register-to-register class instead takes the operation from the low bits of the instruction's 6-bit function field.

The decoder also raises a flag when a register-to-register instruction carries a function code outside the supported set. When that happens, the select still follows the decode equations. The decode itself is a small sum-of-products. The select and the flag are captured in output registers with a synchronous active-high reset, so the downstream ALU sees a stable value for a full cycle.

Top module: `alu_sel_decoder`

## Requirements
- R1: When class bit 2 is 0, the select is {class[0], !class[1], class[1]}. This gives class 000 → 010 (ADD), 010 → 001 (OR) and 001 → 110 (SUBTRACT).
- R2: When class bit 2 is 0, the function field has no effect on the select or on the flag.
- R3: When class bit 2 is 1, each supported function code decodes to its select. The pairs are 100000 → 010 (ADD), 100010 → 110 (SUBTRACT), 100100 → 000 (AND), 100101 → 001 (OR) and 101010 → 111 (set-on-less-than).
- R4: When class bit 2 is 1, the select follows these equations on function bits f3..f0. sel[2] = !f2&f1&!f0. sel[1] = !f2&!f0. sel[0] = !f3&f2&!f1&f0 | f3&!f2&f1&!f0. Function bits 5:4 do not affect the select.
- R5: When class bit 2 is 1 and the 6-bit function code is not one of the five codes in R3, the flag is 1. The select still follows R4.
- R6: When class bit 2 is 0, the flag is 0.
- R7: When class bit 2 is 1, class bits 1:0 have no effect on either output.
- R8: Both outputs are registered. Inputs applied before a rising edge appear on the outputs after that edge and hold until the next edge.
- R9: A synchronous reset sets the select to 000 and the flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_class_i | input | 3 | Operation class from the main controller |
| func_i | input | 6 | Function field of the instruction |
| alu_sel_o | output | 3 | Registered ALU operation select |
| bad_func_o | output | 1 | Registered unsupported-function flag |

## Verification
The bench sweeps every combination of the 8 class codes and 64 function codes. Sweeping all non-R-type classes against all function codes shows that the function field is truly ignored there, rather than merely correct for one sample value. Sweeping all four R-type class values shows that class bits 1:0 are don't-care. The function codes outside the supported five test the flag and the raw equations, and they separate a full 6-bit legality compare from the 4-bit select decode. A reset asserted in the middle of the sweep tests that the registers clear.

// File: rtl/alu_sel_pkg.sv
package alu_sel_pkg;
  localparam int CLASS_W = 3;
  localparam int FUNC_W  = 6;
  localparam int SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_AND = 3'b000,
    SEL_OR  = 3'b001,
    SEL_ADD = 3'b010,
    SEL_SUB = 3'b110,
    SEL_SLT = 3'b111
  } alu_sel_e;

  localparam int NUM_CODES = 5;
  localparam logic [FUNC_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FUNC_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FUNC_W-1:0] FN_AND = 6'b100100;
  localparam logic [FUNC_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FUNC_W-1:0] FN_SLT = 6'b101010;
endpackage

// File: rtl/alu_class_dec.sv
module alu_class_dec
  import alu_sel_pkg::*;
(
  input  logic [1:0]       cls_i,
  output logic [SEL_W-1:0] sel_o
);
  // Direct class: bit0 requests subtract, bit1 requests OR, none requests ADD
  always_comb begin
    sel_o[2] = cls_i[0];
    sel_o[1] = ~cls_i[1];
    sel_o[0] = cls_i[1];
  end
endmodule

// File: rtl/alu_func_dec.sv
module alu_func_dec
  import alu_sel_pkg::*;
(
  input  logic [FUNC_W-1:0] fn_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              legal_o
);
  localparam logic [FUNC_W-1:0] CODES [NUM_CODES] =
    '{FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT};

  logic [NUM_CODES-1:0] hit;

  // Select uses only the low nibble; upper bits are don't-care here
  always_comb begin
    sel_o[2] = ~fn_i[2] & fn_i[1] & ~fn_i[0];
    sel_o[1] = ~fn_i[2] & ~fn_i[0];
    sel_o[0] = (~fn_i[3] & fn_i[2] & ~fn_i[1] & fn_i[0]) |
               ( fn_i[3] & ~fn_i[2] & fn_i[1] & ~fn_i[0]);
  end

  // Legality compares the full field
  for (genvar k = 0; k < NUM_CODES; k++) begin : g_match
    assign hit[k] = (fn_i == CODES[k]);
  end

  assign legal_o = |hit;
endmodule

// File: rtl/alu_sel_decoder.sv
module alu_sel_decoder
  import alu_sel_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [CLASS_W-1:0] op_class_i,
  input  logic [FUNC_W-1:0]  func_i,
  output logic [SEL_W-1:0]   alu_sel_o,
  output logic               bad_func_o
);
  logic [SEL_W-1:0] cls_sel, fn_sel, sel_nxt;
  logic             fn_legal, bad_nxt;
  logic             rtype;

  assign rtype = op_class_i[CLASS_W-1];

  alu_class_dec u_cls (
    .cls_i (op_class_i[1:0]),
    .sel_o (cls_sel)
  );

  alu_func_dec u_fn (
    .fn_i    (func_i),
    .sel_o   (fn_sel),
    .legal_o (fn_legal)
  );

  assign sel_nxt = rtype ? fn_sel : cls_sel;
  assign bad_nxt = rtype & ~fn_legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      alu_sel_o  <= SEL_AND;
      bad_func_o <= 1'b0;
    end else begin
      alu_sel_o  <= sel_nxt;
      bad_func_o <= bad_nxt;
    end
  end

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (alu_sel_o == 3'b000 && !bad_func_o));

  assert_direct_no_flag_R6: assert property (@(posedge clk) disable iff (rst)
    !op_class_i[2] |=> !bad_func_o);

  assert_direct_add_R1: assert property (@(posedge clk) disable iff (rst)
    (op_class_i == 3'b000) |=> (alu_sel_o == 3'b010));

  assert_direct_sub_R1: assert property (@(posedge clk) disable iff (rst)
    (op_class_i == 3'b001) |=> (alu_sel_o == 3'b110));

  assert_rtype_add_R3: assert property (@(posedge clk) disable iff (rst)
    (op_class_i[2] && func_i == 6'b100000) |=> (alu_sel_o == 3'b010 && !bad_func_o));

  assert_rtype_slt_R4: assert property (@(posedge clk) disable iff (rst)
    (op_class_i[2] && func_i[3:0] == 4'b1010) |=> (alu_sel_o == 3'b111));

  assert_upper_bits_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (op_class_i[2] && func_i[5:4] != 2'b10) |=> bad_func_o);
endmodule

// File: tb/alu_sel_decoder_tb.sv
module alu_sel_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op_class_i = '0;
  logic [5:0] func_i = '0;
  logic [2:0] alu_sel_o;
  logic       bad_func_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  alu_sel_decoder dut_i (
    .clk        (clk),
    .rst        (rst),
    .op_class_i (op_class_i),
    .func_i     (func_i),
    .alu_sel_o  (alu_sel_o),
    .bad_func_o (bad_func_o)
  );

  function automatic logic [2:0] exp_sel(input logic [2:0] c, input logic [5:0] f);
    if (!c[2]) begin
      case (c[1:0])
        2'b00:   return 3'b010;
        2'b10:   return 3'b001;
        2'b01:   return 3'b110;
        default: return 3'b101;
      endcase
    end
    case (f[3:0])
      4'b0000: return 3'b010;
      4'b0010: return 3'b110;
      4'b0100: return 3'b000;
      4'b0101: return 3'b001;
      4'b1010: return 3'b111;
      default: return {~f[2] & f[1] & ~f[0], ~f[2] & ~f[0],
                       (~f[3] & f[2] & ~f[1] & f[0]) | (f[3] & ~f[2] & f[1] & ~f[0])};
    endcase
  endfunction

  function automatic logic exp_bad(input logic [2:0] c, input logic [5:0] f);
    if (!c[2]) return 1'b0;
    return !(f == 6'd32 || f == 6'd34 || f == 6'd36 || f == 6'd37 || f == 6'd42);
  endfunction

  task automatic check(input string req, input logic [2:0] es, input logic eb);
    n_vec++;
    if (alu_sel_o !== es || bad_func_o !== eb) begin
      n_bad++;
      $display("FAIL %s class=%b func=%b sel=%b/%b flag=%b/%b (actual/expected)",
               req, op_class_i, func_i, alu_sel_o, es, bad_func_o, eb);
    end
  endtask

  task automatic apply(input logic [2:0] c, input logic [5:0] f);
    @(negedge clk);
    op_class_i = c;
    func_i     = f;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9", 3'b000, 1'b0);
    rst = 1'b0;

    // Explicit named points
    apply(3'b000, 6'b111111); check("R1", 3'b010, 1'b0);
    apply(3'b010, 6'b100000); check("R1", 3'b001, 1'b0);
    apply(3'b001, 6'b100101); check("R1", 3'b110, 1'b0);
    apply(3'b100, 6'b100000); check("R3", 3'b010, 1'b0);
    apply(3'b100, 6'b100010); check("R3", 3'b110, 1'b0);
    apply(3'b100, 6'b100100); check("R3", 3'b000, 1'b0);
    apply(3'b100, 6'b100101); check("R3", 3'b001, 1'b0);
    apply(3'b100, 6'b101010); check("R3", 3'b111, 1'b0);
    apply(3'b100, 6'b001010); check("R5", 3'b111, 1'b1);
    apply(3'b111, 6'b100100); check("R7", 3'b000, 1'b0);

    // R8: outputs hold between edges
    @(negedge clk);
    op_class_i = 3'b010;
    #1;
    check("R8", 3'b000, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R8", 3'b001, 1'b0);

    // Exhaustive sweep: R2 R4 R5 R6 R7
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 64; f++) begin
        apply(c[2:0], f[5:0]);
        check(c[2] ? "R4_R5_R7" : "R2_R6", exp_sel(c[2:0], f[5:0]), exp_bad(c[2:0], f[5:0]));
      end
    end

    // R9: reset mid-stream
    @(negedge clk);
    op_class_i = 3'b100;
    func_i     = 6'b000001;
    rst        = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9", 3'b000, 1'b0);
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule